// File: doc/BRIEF.md
# Addressed Serial Display-Data Receiver

This block sits between a host microcontroller and a segment display driver. The host talks to it over three wires: a select line, a bit clock and a data line. While the select line is low, the host shifts in an 8-bit device address. After raising select, the host shifts in a 56-bit frame. The frame is committed when select drops again. All three link wires are sampled by a fast system clock through two-flop synchronisers, and every link bit is taken on a rising bit-clock edge. The level at which the bit clock rests between transfers therefore does not matter.

A frame carries 44 display bits, an 11-bit field and a trailing bank bit. With the bank bit clear, the frame loads the lower half of the 88 display bits and the six driver-control flags. With the bank bit set, it loads the upper half and its field is ignored. Any transfer with a wrong address or a wrong bit count leaves the stored state untouched.

A force-off input is passed through to the driver as a display-enable signal. Transfers keep being accepted and stored while the display is forced off.

Top module: `disp_link_rx`

## Requirements
- R1: A frame is accepted only if the last eight bits clocked in while `link_sel` was low were 0,0,1,0,0,0,1,0 in transmission order. Earlier extra bits are ignored. With any other address the stored state does not change.
- R2: Data bits are taken on rising `link_clk` edges while `link_sel` is high. Frame bit k is the (k+1)-th data bit sent.
- R3: If frame bit 55 is 0, bits 0..43 are written to `seg_bits[43:0]`, with `seg_bits[i]` = frame bit i. Bits 49..54 are written to `port_mode[0]`, `port_mode[1]`, `port_mode[2]`, `bias_third`, `blank_all` and `standby`, in that order. Bits 44..48 are ignored, and `seg_bits[87:44]` is kept.
- R4: If frame bit 55 is 1, bits 0..43 are written to `seg_bits[87:44]`, with `seg_bits[44+i]` = frame bit i. `seg_bits[43:0]` and all control outputs are kept.
- R5: The frame is committed on the falling edge of `link_sel` only if exactly 56 data bits arrived. With 55 or 57 bits the stored state does not change.
- R6: Reception works the same whether `link_clk` rests low or rests high between bits and transfers.
- R7: `display_on` is the inverse of `force_off`, delayed by the synchroniser. Frames sent while `force_off` is high are still stored.
- R8: After reset, `seg_bits` and all control outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| link_sel | input | 1 | Link select: low for the address phase, high for the data phase |
| link_clk | input | 1 | Link bit clock |
| link_dat | input | 1 | Link serial data |
| force_off | input | 1 | Request to blank the display |
| seg_bits | output | 88 | Stored display bits |
| port_mode | output | 3 | Output-port selection flags |
| bias_third | output | 1 | Bias selection flag |
| blank_all | output | 1 | All-segments-off flag |
| standby | output | 1 | Power-saving flag |
| display_on | output | 1 | Display enable towards the driver |

## Verification
The bench builds the block with its default parameters: device address 8'h44 and two synchroniser stages. Each link half-period lasts four system clocks, so every link edge clears the synchroniser before the next one arrives. This choice reaches the following cases:
- address prefixes longer than eight bits;
- frames one bit short and one bit long;
- nonzero filler bits in the field;
- both resting levels of the bit clock;
- transfers made while the display is forced off.

// File: rtl/disp_link_pkg.sv
package disp_link_pkg;

    localparam int ADDR_W    = 8;
    localparam int HALF_SEGS = 44;
    localparam int FIELD_W   = 11;
    localparam int FRAME_W   = HALF_SEGS + FIELD_W + 1;
    localparam int SEGS      = 2 * HALF_SEGS;
    localparam int FLAGS_W   = 6;
    localparam int FLAG_LSB  = HALF_SEGS + FIELD_W - FLAGS_W;
    localparam int BANK_POS  = FRAME_W - 1;
    localparam int CNT_W     = $clog2(FRAME_W + 2);

    typedef enum logic {
        BANK_LOW  = 1'b0,
        BANK_HIGH = 1'b1
    } bank_e;

    typedef struct packed {
        logic       standby;
        logic       blank_all;
        logic       bias_third;
        logic [2:0] port_mode;
    } drv_ctrl_t;

    typedef struct packed {
        bank_e                 bank;
        logic [HALF_SEGS-1:0]  segs;
        drv_ctrl_t             ctrl;
    } frame_t;

    // Split a received frame (bit k = k-th data bit) into its parts.
    function automatic frame_t unpack_frame(input logic [FRAME_W-1:0] b);
        frame_t f;
        f.bank            = bank_e'(b[BANK_POS]);
        f.segs            = b[HALF_SEGS-1:0];
        f.ctrl.port_mode  = b[FLAG_LSB +: 3];
        f.ctrl.bias_third = b[FLAG_LSB + 3];
        f.ctrl.blank_all  = b[FLAG_LSB + 4];
        f.ctrl.standby    = b[FLAG_LSB + 5];
        return f;
    endfunction

endpackage

// File: rtl/link_sync.sv
module link_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[s] <= '0;
            else     stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/link_shifter.sv
module link_shifter
    import disp_link_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR = 8'h44
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   sel_s,
    input  logic   bclk_s,
    input  logic   dat_s,
    output logic   frame_stb,
    output logic   frame_ok,
    output frame_t frame
);
    localparam int ACNT_W = $clog2(ADDR_W + 1);

    logic                sel_q, bclk_q;
    logic [ADDR_W-1:0]   addr_sr;
    logic [ACNT_W-1:0]   addr_cnt;
    logic                addr_hit;
    logic [FRAME_W-1:0]  data_sr;
    logic [CNT_W-1:0]    data_cnt;

    logic bit_edge, sel_rise, sel_fall;
    assign bit_edge = bclk_s & ~bclk_q;
    assign sel_rise = sel_s & ~sel_q;
    assign sel_fall = ~sel_s & sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q    <= 1'b0;
            bclk_q   <= 1'b0;
            addr_sr  <= '0;
            addr_cnt <= '0;
            addr_hit <= 1'b0;
            data_sr  <= '0;
            data_cnt <= '0;
        end else begin
            sel_q  <= sel_s;
            bclk_q <= bclk_s;
            if (sel_rise) begin
                addr_hit <= (addr_cnt == ACNT_W'(ADDR_W)) && (addr_sr == DEV_ADDR);
                data_cnt <= '0;
            end else if (sel_fall) begin
                addr_hit <= 1'b0;
                addr_cnt <= '0;
            end else if (bit_edge) begin
                if (sel_s) begin
                    data_sr <= {dat_s, data_sr[FRAME_W-1:1]};
                    if (data_cnt != CNT_W'(FRAME_W + 1)) data_cnt <= data_cnt + 1'b1;
                end else begin
                    addr_sr <= {dat_s, addr_sr[ADDR_W-1:1]};
                    if (addr_cnt != ACNT_W'(ADDR_W)) addr_cnt <= addr_cnt + 1'b1;
                end
            end
        end
    end

    assign frame_stb = sel_fall;
    assign frame_ok  = addr_hit && (data_cnt == CNT_W'(FRAME_W));
    assign frame     = unpack_frame(data_sr);

    // R5: the bit counter saturates just above a full frame
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
        data_cnt <= CNT_W'(FRAME_W + 1));
    // R2: each data phase starts counting from zero
    p_cnt_clear_r2: assert property (@(posedge clk) disable iff (rst)
        sel_rise |=> data_cnt == '0);
    // R1: address state is dropped after every transfer
    p_addr_clear_r1: assert property (@(posedge clk) disable iff (rst)
        sel_fall |=> (addr_cnt == '0) && !addr_hit);
endmodule

// File: rtl/frame_store.sv
module frame_store
    import disp_link_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            stb,
    input  logic            ok,
    input  frame_t          frm,
    output logic [SEGS-1:0] seg_q,
    output drv_ctrl_t       ctrl_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q  <= '0;
            ctrl_q <= '0;
        end else if (stb && ok) begin
            case (frm.bank)
                BANK_LOW: begin
                    seg_q[HALF_SEGS-1:0] <= frm.segs;
                    ctrl_q               <= frm.ctrl;
                end
                default: seg_q[SEGS-1:HALF_SEGS] <= frm.segs;
            endcase
        end
    end

    // R5 / R1: rejected or absent frames leave the stored state alone
    p_discard_r5: assert property (@(posedge clk) disable iff (rst)
        !(stb && ok) |=> $stable(seg_q) && $stable(ctrl_q));
    // R3: low-bank commit keeps the upper half
    p_low_bank_r3: assert property (@(posedge clk) disable iff (rst)
        (stb && ok && frm.bank == BANK_LOW) |=>
            $stable(seg_q[SEGS-1:HALF_SEGS]) && seg_q[HALF_SEGS-1:0] == $past(frm.segs));
    // R4: high-bank commit keeps the lower half and the control flags
    p_high_bank_r4: assert property (@(posedge clk) disable iff (rst)
        (stb && ok && frm.bank == BANK_HIGH) |=>
            $stable(seg_q[HALF_SEGS-1:0]) && $stable(ctrl_q)
            && seg_q[SEGS-1:HALF_SEGS] == $past(frm.segs));
endmodule

// File: rtl/disp_link_rx.sv
module disp_link_rx
    import disp_link_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR    = 8'h44,
    parameter int                SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        link_sel,
    input  logic        link_clk,
    input  logic        link_dat,
    input  logic        force_off,
    output logic [87:0] seg_bits,
    output logic [2:0]  port_mode,
    output logic        bias_third,
    output logic        blank_all,
    output logic        standby,
    output logic        display_on
);
    logic [3:0] raw_in, sync_out;
    logic       stb, ok;
    frame_t     frm;
    drv_ctrl_t  ctrl;

    assign raw_in = {force_off, link_dat, link_clk, link_sel};

    link_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(raw_in), .q(sync_out)
    );

    link_shifter #(.DEV_ADDR(DEV_ADDR)) u_shift (
        .clk(clk), .rst(rst),
        .sel_s(sync_out[0]), .bclk_s(sync_out[1]), .dat_s(sync_out[2]),
        .frame_stb(stb), .frame_ok(ok), .frame(frm)
    );

    frame_store u_store (
        .clk(clk), .rst(rst), .stb(stb), .ok(ok), .frm(frm),
        .seg_q(seg_bits), .ctrl_q(ctrl)
    );

    assign port_mode  = ctrl.port_mode;
    assign bias_third = ctrl.bias_third;
    assign blank_all  = ctrl.blank_all;
    assign standby    = ctrl.standby;
    assign display_on = ~sync_out[3];

    // R8: state is clear in the first cycle after reset
    p_reset_clear_r8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (seg_bits == '0) && (ctrl == '0));
endmodule

// File: tb/disp_link_rx_tb.sv
module disp_link_rx_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  HB         = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        link_sel = 1'b0, link_clk = 1'b0, link_dat = 1'b0, force_off = 1'b0;
    logic [87:0] seg_bits;
    logic [2:0]  port_mode;
    logic        bias_third, blank_all, standby, display_on;

    always #(CLK_PERIOD/2) clk = ~clk;

    disp_link_rx dut_i (
        .clk(clk), .rst(rst), .link_sel(link_sel), .link_clk(link_clk),
        .link_dat(link_dat), .force_off(force_off), .seg_bits(seg_bits),
        .port_mode(port_mode), .bias_third(bias_third), .blank_all(blank_all),
        .standby(standby), .display_on(display_on)
    );

    typedef struct {
        logic [87:0] seg;
        logic [5:0]  ctrl;
        logic        on;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;
    logic [87:0] mdl_seg = '0;
    logic [5:0]  mdl_ctrl = '0;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit good, input string tag, input string what,
                         input logic [87:0] act, input logic [87:0] exp);
        n_chk++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // monitor: compare each queued expectation against the ports
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                exp_t e;
                logic [5:0] act_ctrl;
                e = sb_q.pop_front();
                act_ctrl = {standby, blank_all, bias_third, port_mode};
                check(seg_bits === e.seg, e.tag, "seg_bits", seg_bits, e.seg);
                check(act_ctrl === e.ctrl, e.tag, "control", 88'(act_ctrl), 88'(e.ctrl));
                check(display_on === e.on, e.tag, "display_on", 88'(display_on), 88'(e.on));
            end
        end
    end

    function automatic logic [63:0] mk(input logic [43:0] s, input logic [5:0] c,
                                       input logic dir, input logic [4:0] pad);
        logic [63:0] f = '0;
        f[43:0]  = s;
        f[48:44] = pad;
        f[54:49] = c;
        f[55]    = dir;
        return f;
    endfunction

    task automatic apply(input logic [43:0] s, input logic [5:0] c, input logic dir);
        if (!dir) begin
            mdl_seg[43:0] = s;
            mdl_ctrl      = c;
        end else begin
            mdl_seg[87:44] = s;
        end
    endtask

    task automatic send_bit(input logic b, input bit idle_hi);
        if (idle_hi) begin
            link_clk = 1'b0; link_dat = b; tick(HB);
            link_clk = 1'b1; tick(HB);
        end else begin
            link_dat = b; tick(HB);
            link_clk = 1'b1; tick(HB);
            link_clk = 1'b0;
        end
    endtask

    task automatic send(input logic [15:0] abits, input int an,
                        input logic [63:0] dbits, input int dn, input bit idle_hi);
        link_clk = idle_hi; tick(HB);
        for (int i = 0; i < an; i++) send_bit(abits[i], idle_hi);
        tick(HB);
        link_sel = 1'b1; tick(HB);
        for (int i = 0; i < dn; i++) send_bit(dbits[i], idle_hi);
        tick(HB);
        link_sel = 1'b0;
        tick(12);
    endtask

    task automatic expect_state(input string tag);
        exp_t e;
        e.seg = mdl_seg; e.ctrl = mdl_ctrl; e.on = ~force_off; e.tag = tag;
        sb_q.push_back(e);
        tick(3);
    endtask

    localparam logic [15:0] GOOD = 16'h0044;

    initial begin
        tick(5);
        rst = 1'b0;
        tick(3);
        expect_state("R8 reset");

        // R2 R3: low bank with control flags, clock resting low
        send(GOOD, 8, mk(44'h123_4567_89AB, 6'b101101, 1'b0, 5'h0), 56, 1'b0);
        apply(44'h123_4567_89AB, 6'b101101, 1'b0);
        expect_state("R2 R3 low bank");

        // R4: high bank, field bits must not reach control
        send(GOOD, 8, mk(44'hFED_CBA9_8765, 6'b010010, 1'b1, 5'h0), 56, 1'b0);
        apply(44'hFED_CBA9_8765, 6'b010010, 1'b1);
        expect_state("R4 high bank");

        // R1: bit-reversed address is rejected
        send(16'h0022, 8, mk(44'h0F0_F0F0_F0F0, 6'b111111, 1'b0, 5'h0), 56, 1'b0);
        expect_state("R1 wrong address");

        // R5: one bit short, then one bit long
        send(GOOD, 8, mk(44'h555_5555_5555, 6'b000111, 1'b0, 5'h0), 55, 1'b0);
        expect_state("R5 short frame");
        send(GOOD, 8, mk(44'h555_5555_5555, 6'b000111, 1'b0, 5'h0), 57, 1'b0);
        expect_state("R5 long frame");

        // R3: filler bits 44..48 are ignored
        send(GOOD, 8, mk(44'hAAA_0000_5555, 6'b010101, 1'b0, 5'h1F), 56, 1'b0);
        apply(44'hAAA_0000_5555, 6'b010101, 1'b0);
        expect_state("R3 filler ignored");

        // R6: clock resting high, both banks
        send(GOOD, 8, mk(44'h0C3_A5C3_A5C3, 6'b110011, 1'b0, 5'h0), 56, 1'b1);
        apply(44'h0C3_A5C3_A5C3, 6'b110011, 1'b0);
        expect_state("R6 idle high low bank");
        send(GOOD, 8, mk(44'h3C0_5A3C_5A3C, 6'b000000, 1'b1, 5'h0), 56, 1'b1);
        apply(44'h3C0_5A3C_5A3C, 6'b000000, 1'b1);
        expect_state("R6 idle high high bank");
        link_clk = 1'b0; tick(HB);

        // R7: stored while forced off
        force_off = 1'b1; tick(5);
        send(GOOD, 8, mk(44'h9876_5432_10F & 44'hFFF_FFFF_FFFF, 6'b100001, 1'b1, 5'h0), 56, 1'b0);
        apply(44'h9876_5432_10F & 44'hFFF_FFFF_FFFF, 6'b100001, 1'b1);
        expect_state("R7 forced off");
        force_off = 1'b0; tick(5);
        expect_state("R7 released");

        // R1: longer address prefix, last eight bits decide
        send(16'h0113, 10, mk(44'h1111_2222_333 & 44'hFFF_FFFF_FFFF, 6'b011110, 1'b0, 5'h0), 56, 1'b0);
        apply(44'h1111_2222_333 & 44'hFFF_FFFF_FFFF, 6'b011110, 1'b0);
        expect_state("R1 long prefix");

        tick(5);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule